// File: doc/BRIEF.md
# Management Request Address Filter

This block sits behind the deserialiser of a shared, open-drain management serial line and decides whether each completed request is meant for this device. Once a request header has been shifted in, the block compares its hub identifier and 3-bit chip address against the local values. It raises a match flag when the hub identifier agrees or is the all-ones broadcast value. It fires an execute strobe only when both address parts agree and the request is free of errors.

Each executed request opens a response window. A countdown measured in serial bit times shows how long the responder has left to start its reply. The window closes when the reply starts, when the countdown runs out, or when an address-arbitration packet lands on the line first. In that last case the pending operation is dropped and an abort strobe is raised.

The local hub identifier comes up as the broadcast value and can be reprogrammed through a write strobe. The chip address is fixed at a zero top bit over two strap pins.

Top module: `mgmt_addr_filter`

## Requirements
- R1: One clock after `frame_done_i`, `match_o` pulses high for one cycle if `rx_hub_i` equals the local hub identifier. A different non-broadcast value leaves it low.
- R2: A request whose `rx_hub_i` is all ones (broadcast) raises `match_o` and may execute, whatever the local hub identifier is.
- R3: After reset the local hub identifier is all ones. A cycle with `hub_we_i` high loads `hub_wdata_i`, which applies to requests from the next cycle on.
- R4: Execution needs `rx_chip_i[2]` = 0 and `rx_chip_i[1:0]` = `strap_i`. A mismatch of either part blocks `execute_o` but does not affect `match_o`.
- R5: A request with `frame_err_i` high at `frame_done_i` never executes and opens no response window.
- R6: A write request (`rx_write_i` = 1) whose `rx_len_i` (long words) exceeds 2 is treated as an error and not executed. Reads execute for any length.
- R7: `execute_o` is a single-cycle pulse, one clock after `frame_done_i`, and occurs once per valid addressed request.
- R8: If `arb_pkt_i` is seen while a response window is open and no response starts in that cycle, `abort_o` pulses for one cycle in the next clock and the window closes. With no window open, `arb_pkt_i` causes no abort.
- R9: `resp_timer_o` loads 12 in the same cycle as `execute_o` and falls by one per `bit_tick_i`. The window is open while it is non-zero. It clears on `resp_start_i` or on an abort, and it reads 0 after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| strap_i | input | 2 | Strapped low bits of the chip address |
| hub_we_i | input | 1 | Load strobe for the local hub identifier |
| hub_wdata_i | input | HUB_W | New local hub identifier |
| frame_done_i | input | 1 | Request header complete, fields valid |
| frame_err_i | input | 1 | Transfer error on this request |
| rx_hub_i | input | HUB_W | Received hub identifier |
| rx_chip_i | input | 3 | Received chip address |
| rx_write_i | input | 1 | Request is a write |
| rx_len_i | input | LEN_W | Requested length in long words |
| arb_pkt_i | input | 1 | Address-arbitration packet detected |
| bit_tick_i | input | 1 | One serial bit time elapsed |
| resp_start_i | input | 1 | Own response has begun |
| match_o | output | 1 | Hub identifier match or broadcast |
| execute_o | output | 1 | Execute the addressed request |
| abort_o | output | 1 | Pending request cancelled |
| resp_timer_o | output | CNT_W | Bit times left to start the response |

## Verification
The bench uses the defaults: an 8-bit hub identifier, a 4-bit length field, a two-word write limit and a 12-bit-time deadline. This keeps the all-ones broadcast value reachable and lets the length field exceed the write limit, so both sides of that rule get exercised. It also lets the full countdown be walked tick by tick down to zero. With the straps set to a non-symmetric value, a swapped or ignored strap bit shows up as a wrong execute decision.

// File: rtl/mgmt_filt_pkg.sv
`timescale 1ns/1ps
package mgmt_filt_pkg;
  typedef struct packed {
    logic hub_hit;
    logic chip_hit;
    logic len_ok;
  } addr_dec_t;
endpackage

// File: rtl/mgmt_hub_reg.sv
`timescale 1ns/1ps
module mgmt_hub_reg #(
  parameter int HUB_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [HUB_W-1:0] wdata_i,
  output logic [HUB_W-1:0] hub_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   hub_o <= '1;
    else if (we_i) hub_o <= wdata_i;
  end
endmodule

// File: rtl/mgmt_addr_cmp.sv
`timescale 1ns/1ps
module mgmt_addr_cmp
  import mgmt_filt_pkg::*;
#(
  parameter int HUB_W        = 8,
  parameter int LEN_W        = 4,
  parameter int MAX_WR_WORDS = 2,
  parameter bit BCAST_EN     = 1'b1
) (
  input  logic [HUB_W-1:0] local_hub_i,
  input  logic [HUB_W-1:0] rx_hub_i,
  input  logic [2:0]       rx_chip_i,
  input  logic [1:0]       strap_i,
  input  logic             rx_write_i,
  input  logic [LEN_W-1:0] rx_len_i,
  output addr_dec_t        dec_o
);
  localparam logic [LEN_W-1:0] WR_LIMIT = LEN_W'(MAX_WR_WORDS);

  logic bcast;

  generate
    if (BCAST_EN) begin : g_bcast
      assign bcast = &rx_hub_i;
    end else begin : g_no_bcast
      assign bcast = 1'b0;
    end
  endgenerate

  always_comb begin
    dec_o.hub_hit  = (rx_hub_i == local_hub_i) || bcast;
    dec_o.chip_hit = (rx_chip_i == {1'b0, strap_i});
    dec_o.len_ok   = !(rx_write_i && (rx_len_i > WR_LIMIT));
  end
endmodule

// File: rtl/mgmt_resp_window.sv
`timescale 1ns/1ps
module mgmt_resp_window #(
  parameter int RESP_BITS = 12,
  parameter int CNT_W     = $clog2(RESP_BITS + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             open_i,
  input  logic             bit_tick_i,
  input  logic             resp_start_i,
  input  logic             arb_pkt_i,
  output logic             abort_o,
  output logic [CNT_W-1:0] timer_o
);
  localparam logic [CNT_W-1:0] LOAD = CNT_W'(RESP_BITS);

  logic pending;
  assign pending = (timer_o != '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      timer_o <= '0;
      abort_o <= 1'b0;
    end else begin
      abort_o <= pending && arb_pkt_i && !resp_start_i;
      // a new window wins over any close event in the same cycle
      if (open_i)                          timer_o <= LOAD;
      else if (resp_start_i || arb_pkt_i)  timer_o <= '0;
      else if (bit_tick_i && pending)      timer_o <= timer_o - 1'b1;
    end
  end
endmodule

// File: rtl/mgmt_addr_filter.sv
`timescale 1ns/1ps
module mgmt_addr_filter
  import mgmt_filt_pkg::*;
#(
  parameter int HUB_W        = 8,
  parameter int LEN_W        = 4,
  parameter int MAX_WR_WORDS = 2,
  parameter int RESP_BITS    = 12,
  parameter bit BCAST_EN     = 1'b1,
  localparam int CNT_W       = $clog2(RESP_BITS + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [1:0]       strap_i,
  input  logic             hub_we_i,
  input  logic [HUB_W-1:0] hub_wdata_i,
  input  logic             frame_done_i,
  input  logic             frame_err_i,
  input  logic [HUB_W-1:0] rx_hub_i,
  input  logic [2:0]       rx_chip_i,
  input  logic             rx_write_i,
  input  logic [LEN_W-1:0] rx_len_i,
  input  logic             arb_pkt_i,
  input  logic             bit_tick_i,
  input  logic             resp_start_i,
  output logic             match_o,
  output logic             execute_o,
  output logic             abort_o,
  output logic [CNT_W-1:0] resp_timer_o
);
  logic [HUB_W-1:0] local_hub;
  addr_dec_t        dec;
  logic             accept;

  mgmt_hub_reg #(.HUB_W(HUB_W)) u_hub_reg (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (hub_we_i),
    .wdata_i (hub_wdata_i),
    .hub_o   (local_hub)
  );

  mgmt_addr_cmp #(
    .HUB_W(HUB_W), .LEN_W(LEN_W),
    .MAX_WR_WORDS(MAX_WR_WORDS), .BCAST_EN(BCAST_EN)
  ) u_cmp (
    .local_hub_i (local_hub),
    .rx_hub_i    (rx_hub_i),
    .rx_chip_i   (rx_chip_i),
    .strap_i     (strap_i),
    .rx_write_i  (rx_write_i),
    .rx_len_i    (rx_len_i),
    .dec_o       (dec)
  );

  assign accept = frame_done_i && !frame_err_i &&
                  dec.hub_hit && dec.chip_hit && dec.len_ok;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      match_o   <= 1'b0;
      execute_o <= 1'b0;
    end else begin
      match_o   <= frame_done_i && dec.hub_hit;
      execute_o <= accept;
    end
  end

  mgmt_resp_window #(.RESP_BITS(RESP_BITS), .CNT_W(CNT_W)) u_win (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .open_i       (accept),
    .bit_tick_i   (bit_tick_i),
    .resp_start_i (resp_start_i),
    .arb_pkt_i    (arb_pkt_i),
    .abort_o      (abort_o),
    .timer_o      (resp_timer_o)
  );
endmodule

// File: rtl/mgmt_addr_filter_chk.sv
`timescale 1ns/1ps
module mgmt_addr_filter_chk #(
  parameter int HUB_W     = 8,
  parameter int LEN_W     = 4,
  parameter int RESP_BITS = 12,
  parameter int CNT_W     = $clog2(RESP_BITS + 1)
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [1:0]       strap_i,
  input logic             frame_done_i,
  input logic             frame_err_i,
  input logic [HUB_W-1:0] rx_hub_i,
  input logic [2:0]       rx_chip_i,
  input logic             arb_pkt_i,
  input logic             bit_tick_i,
  input logic             resp_start_i,
  input logic             match_o,
  input logic             execute_o,
  input logic             abort_o,
  input logic [CNT_W-1:0] resp_timer_o
);
  a_r1_match_after_frame: assert property (@(posedge clk_i) disable iff (!rst_ni)
    match_o |-> $past(frame_done_i));

  a_r2_bcast_matches: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (frame_done_i && (&rx_hub_i)) |=> match_o);

  a_r4_chip_msb_blocks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (frame_done_i && (rx_chip_i[2] || rx_chip_i[1:0] != strap_i)) |=> !execute_o);

  a_r5_err_no_exec: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (frame_done_i && frame_err_i) |=> !execute_o);

  a_r7_exec_needs_match: assert property (@(posedge clk_i) disable iff (!rst_ni)
    execute_o |-> match_o);

  a_r7_exec_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (execute_o && !$past(frame_done_i, 2)) |=> !execute_o);

  a_r8_abort_needs_window: assert property (@(posedge clk_i) disable iff (!rst_ni)
    abort_o |-> ($past(resp_timer_o) != '0 && $past(arb_pkt_i)));

  a_r9_load_on_exec: assert property (@(posedge clk_i) disable iff (!rst_ni)
    execute_o |-> (resp_timer_o == CNT_W'(RESP_BITS)));

  a_r9_tick_decrements: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (resp_timer_o != '0 && bit_tick_i && !resp_start_i && !arb_pkt_i && !frame_done_i)
    |=> (resp_timer_o == $past(resp_timer_o) - 1'b1));

  a_r9_bounded: assert property (@(posedge clk_i) disable iff (!rst_ni)
    resp_timer_o <= CNT_W'(RESP_BITS));
endmodule

bind mgmt_addr_filter mgmt_addr_filter_chk #(
  .HUB_W(HUB_W), .LEN_W(LEN_W), .RESP_BITS(RESP_BITS), .CNT_W(CNT_W)
) u_chk (.*);

// File: tb/mgmt_addr_filter_bench.sv
`timescale 1ns/1ps
module mgmt_addr_filter_bench;
  localparam int HUB_W = 8;
  localparam int LEN_W = 4;
  localparam int CNT_W = 4;
  localparam logic [HUB_W-1:0] MY_HUB = 8'h5A;
  localparam logic [1:0]       MY_STRAP = 2'b10;

  typedef struct packed {
    logic [7:0] hub;
    logic [2:0] chip;
    logic       wr;
    logic [3:0] len;
    logic       err;
    logic       exp_m;
    logic       exp_e;
  } vec_t;

  localparam int NV = 8;
  localparam vec_t VEC [NV] = '{
    {8'h5A, 3'b010, 1'b0, 4'd5,  1'b0, 1'b1, 1'b1},  // R1 plain hit
    {8'hFF, 3'b010, 1'b1, 4'd2,  1'b0, 1'b1, 1'b1},  // R2 broadcast, R6 write at limit
    {8'h5A, 3'b110, 1'b0, 4'd1,  1'b0, 1'b1, 1'b0},  // R4 msb set
    {8'h5A, 3'b011, 1'b0, 4'd1,  1'b0, 1'b1, 1'b0},  // R4 strap mismatch
    {8'h5B, 3'b010, 1'b0, 4'd1,  1'b0, 1'b0, 1'b0},  // R1 other hub
    {8'h5A, 3'b010, 1'b1, 4'd3,  1'b0, 1'b1, 1'b0},  // R6 write too long
    {8'h5A, 3'b010, 1'b0, 4'd1,  1'b1, 1'b1, 1'b0},  // R5 error
    {8'h5A, 3'b010, 1'b0, 4'd15, 1'b0, 1'b1, 1'b1}   // R6 long read
  };

  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic [1:0] strap_i = MY_STRAP;
  logic hub_we_i = 0, frame_done_i = 0, frame_err_i = 0, rx_write_i = 0;
  logic arb_pkt_i = 0, bit_tick_i = 0, resp_start_i = 0;
  logic [HUB_W-1:0] hub_wdata_i = '0, rx_hub_i = '0;
  logic [2:0] rx_chip_i = '0;
  logic [LEN_W-1:0] rx_len_i = '0;
  logic match_o, execute_o, abort_o;
  logic [CNT_W-1:0] resp_timer_o;

  int n_chk = 0, n_fail = 0;

  always #4 clk_i = ~clk_i;

  mgmt_addr_filter u_mgmt_addr_filter (.*);

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d", tag, act, exp);
    end
  endtask

  // drive one header; returns sampled one clock later
  task automatic frame(input logic [7:0] h, input logic [2:0] c, input logic w,
                       input logic [3:0] l, input logic e);
    @(negedge clk_i);
    rx_hub_i = h; rx_chip_i = c; rx_write_i = w; rx_len_i = l;
    frame_err_i = e; frame_done_i = 1'b1;
    @(negedge clk_i);
    frame_done_i = 1'b0; frame_err_i = 1'b0;
  endtask

  task automatic pulse_resp();
    @(negedge clk_i); resp_start_i = 1'b1;
    @(negedge clk_i); resp_start_i = 1'b0;
  endtask

  task automatic pulse_arb();
    @(negedge clk_i); arb_pkt_i = 1'b1;
    @(negedge clk_i); arb_pkt_i = 1'b0;
  endtask

  task automatic pulse_tick();
    @(negedge clk_i); bit_tick_i = 1'b1;
    @(negedge clk_i); bit_tick_i = 1'b0;
  endtask

  initial begin
    #(8 * 200000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: got 0 expected 1");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    chk("R9 reset timer", resp_timer_o, 0);
    chk("R1 reset match", match_o, 0);
    rst_ni = 1'b1;

    // R3: local hub starts as all ones
    frame(8'h5A, 3'b010, 1'b0, 4'd1, 1'b0);
    chk("R3 reset hub no match", match_o, 0);
    frame(8'hFF, 3'b010, 1'b0, 4'd1, 1'b0);
    chk("R3 reset hub bcast", execute_o, 1);
    pulse_resp();

    // R3: program hub
    @(negedge clk_i); hub_we_i = 1'b1; hub_wdata_i = MY_HUB;
    @(negedge clk_i); hub_we_i = 1'b0;

    for (int i = 0; i < NV; i++) begin
      pulse_resp();
      frame(VEC[i].hub, VEC[i].chip, VEC[i].wr, VEC[i].len, VEC[i].err);
      chk($sformatf("R1 match vec %0d", i), match_o, VEC[i].exp_m);
      chk($sformatf("R7 exec vec %0d", i), execute_o, VEC[i].exp_e);
      chk($sformatf("R9 window vec %0d", i), resp_timer_o, VEC[i].exp_e ? 12 : 0);
      @(negedge clk_i);
      chk($sformatf("R7 single pulse vec %0d", i), execute_o, 0);
    end

    // R9: countdown to zero
    pulse_resp();
    frame(MY_HUB, 3'b010, 1'b0, 4'd1, 1'b0);
    for (int k = 11; k >= 0; k--) begin
      pulse_tick();
      chk("R9 countdown", resp_timer_o, k);
    end
    pulse_arb();
    chk("R8 no abort after timeout", abort_o, 0);

    // R8: abort while pending
    frame(MY_HUB, 3'b010, 1'b0, 4'd1, 1'b0);
    pulse_tick();
    @(negedge clk_i); arb_pkt_i = 1'b1;
    @(negedge clk_i); arb_pkt_i = 1'b0;
    chk("R8 abort pulse", abort_o, 1);
    chk("R8 window closed", resp_timer_o, 0);
    @(negedge clk_i);
    chk("R8 abort single", abort_o, 0);

    // R8/R9: response started first, then arbitration
    frame(MY_HUB, 3'b010, 1'b0, 4'd1, 1'b0);
    pulse_resp();
    chk("R9 resp clears", resp_timer_o, 0);
    pulse_arb();
    chk("R8 no abort after resp", abort_o, 0);

    // R4: strap change follows pins
    strap_i = 2'b01;
    frame(MY_HUB, 3'b001, 1'b0, 4'd1, 1'b0);
    chk("R4 new strap exec", execute_o, 1);
    frame(MY_HUB, 3'b010, 1'b0, 4'd1, 1'b0);
    chk("R4 old strap no exec", execute_o, 0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule